// File: doc/BRIEF.md
# Chainable Dual 8-Bit Timer

This block holds two 8-bit timer channels. Each channel has a counter, two compare values (A and B), a clock-select code, a clear-select code, a match flag for each compare value, and one timer output pin. A shared single-cycle tick strobe stands in for the prescaler. Each channel counts on the tick when its clock-select code is 001, 010 or 011. It holds its count for 000 and for 101 to 111.

Clock-select code 100 chains the two channels together. If channel 0 carries code 100, the pair acts as one 16-bit counter: channel 0 holds the upper byte and channel 1 the lower byte. Channel 0's flags and pin then react to full 16-bit matches. Channel 1's flags and pin react to matches of the lower byte alone, and only channel 0's clear setting can clear the count. If instead channel 1 carries code 100, channel 1 advances once per compare-A match of channel 0. In that mode each channel keeps its own clear, flags and pin.

All configuration arrives on ports and is meant to be held steady while the timer runs. Everything is synchronous to one clock.

Top module: `tmr_pair`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, both counters are 0 and all flags and both pins are 0.
- R2: A channel whose clock-select code is 001, 010 or 011 adds one to its counter on each clock edge where `tick_i` is high. It holds the counter when `tick_i` is low. It also holds when its code is 000, 101, 110 or 111.
- R3: The clear-select code works as follows: 00 never clears, 01 clears on a compare-A match, 10 clears on a compare-B match, and 11 clears on any clock edge where that channel's `ext_clr_i` bit is high. A clear loads 0 and overrides an increment in the same cycle.
- R4: A match happens on a counting event while the counter equals the compare value, so with clear-on-A and compare value N the counter runs through N+1 states. A match sets its flag on that edge. A `flag_clr_i` pulse lowers both flags of its channel, but a match in the same cycle keeps its flag set.
- R5: `out_sel_i[c][1:0]` sets the pin action on a compare-A match and `[3:2]` sets it on a compare-B match. The codes are 00 hold, 01 drive 0, 10 drive 1 and 11 toggle. When both matches happen together, the B action applies.
- R6: With channel 0's code at 100, the counter {cnt_o[0], cnt_o[1]} adds one on each tick. The lower byte rolls from FF to 00 and carries into the upper byte on the same tick. This mode takes precedence over channel 1's code.
- R7: In 16-bit mode, channel 0's flags are set only on a match of all 16 bits against {cmp_x_i[0], cmp_x_i[1]}. Channel 1's flags are set on a match of the lower byte alone.
- R8: In 16-bit mode, channel 0's clear code clears the whole 16-bit count, either on a 16-bit match or on `ext_clr_i[0]`. Channel 1's clear code and `ext_clr_i[1]` have no effect.
- R9: In 16-bit mode, pin 0 follows `out_sel_i[0]` on 16-bit matches and pin 1 follows `out_sel_i[1]` on lower-byte matches.
- R10: With channel 1's code at 100 and channel 0's code not 100, channel 1 adds one for each compare-A match of channel 0. Channel 1 uses its own clear code, flags and pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Single-cycle count strobe |
| cks_i | input | 2x3 | Clock-select code per channel |
| clr_sel_i | input | 2x2 | Clear-select code per channel |
| ext_clr_i | input | 2 | External clear level per channel |
| cmp_a_i | input | 2xW | Compare value A per channel |
| cmp_b_i | input | 2xW | Compare value B per channel |
| out_sel_i | input | 2x4 | Pin action select per channel (B in [3:2], A in [1:0]) |
| flag_clr_i | input | 2 | Flag clear strobe per channel |
| cnt_o | output | 2xW | Counter value per channel |
| flag_a_o | output | 2 | Compare-A match flag per channel |
| flag_b_o | output | 2 | Compare-B match flag per channel |
| tmo_o | output | 2 | Timer output pin per channel |

## Verification
The assertions assume that clock-select, clear-select and compare values are not changed between the cycle they sample and the cycle they check. The carry and chain properties compare a count against its value one edge earlier under the same mode. The stimulus respects this: it changes configuration only while reset is held, then only pulses `tick_i`, `ext_clr_i` and `flag_clr_i`. Expected counts come from modular arithmetic on the tick number, for example k mod (N+1) or floor(k/3) mod 3.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] CKS_OFF   = 3'b000;
  localparam logic [2:0] CKS_CHAIN = 3'b100;

  localparam logic [1:0] CLR_NONE = 2'b00;
  localparam logic [1:0] CLR_MA   = 2'b01;
  localparam logic [1:0] CLR_MB   = 2'b10;
  localparam logic [1:0] CLR_PIN  = 2'b11;

  typedef enum logic [1:0] {
    PA_HOLD = 2'b00,
    PA_LOW  = 2'b01,
    PA_HIGH = 2'b10,
    PA_TOG  = 2'b11
  } pin_act_e;

  function automatic logic cks_runs(input logic [2:0] cks);
    return (cks == 3'b001) || (cks == 3'b010) || (cks == 3'b011);
  endfunction

  function automatic logic clr_pick(input logic [1:0] sel, input logic ma,
                                    input logic mb, input logic ext);
    case (sel)
      CLR_NONE: return 1'b0;
      CLR_MA:   return ma;
      CLR_MB:   return mb;
      default:  return ext;
    endcase
  endfunction
endpackage

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0); // R3
  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> cnt_o == $past(cnt_o) + W'(1)); // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_o)); // R2
endmodule

// File: rtl/tmr_mode.sv
module tmr_mode
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                tick_i,
  input  logic [1:0][2:0]     cks_i,
  input  logic [1:0][1:0]     clr_sel_i,
  input  logic [1:0]          ext_clr_i,
  input  logic [1:0][W-1:0]   cnt_i,
  input  logic [1:0][W-1:0]   cmp_a_i,
  input  logic [1:0][W-1:0]   cmp_b_i,
  output logic                mode16_o,
  output logic [1:0]          inc_o,
  output logic [1:0]          clr_o,
  output logic [1:0]          match_a_o,
  output logic [1:0]          match_b_o
);
  localparam int W2 = 2 * W;

  logic          chain1;
  logic          ev0, ev1;
  logic [W2-1:0] full_cnt, full_a, full_b;
  logic          eq_a0, eq_b0, eq_a1, eq_b1;

  assign mode16_o = (cks_i[0] == CKS_CHAIN);
  assign chain1   = !mode16_o && (cks_i[1] == CKS_CHAIN);
  assign full_cnt = {cnt_i[0], cnt_i[1]};
  assign full_a   = {cmp_a_i[0], cmp_a_i[1]};
  assign full_b   = {cmp_b_i[0], cmp_b_i[1]};
  assign eq_a0    = (cnt_i[0] == cmp_a_i[0]);
  assign eq_b0    = (cnt_i[0] == cmp_b_i[0]);
  assign eq_a1    = (cnt_i[1] == cmp_a_i[1]);
  assign eq_b1    = (cnt_i[1] == cmp_b_i[1]);

  always_comb begin
    ev0 = 1'b0;
    ev1 = 1'b0;
    if (mode16_o) begin
      match_a_o[0] = tick_i && (full_cnt == full_a);
      match_b_o[0] = tick_i && (full_cnt == full_b);
      match_a_o[1] = tick_i && eq_a1;
      match_b_o[1] = tick_i && eq_b1;
      inc_o[1]     = tick_i;
      inc_o[0]     = tick_i && (&cnt_i[1]);
    end else begin
      ev0          = tick_i && cks_runs(cks_i[0]);
      match_a_o[0] = ev0 && eq_a0;
      match_b_o[0] = ev0 && eq_b0;
      // chained channel advances on channel 0's A matches
      ev1          = chain1 ? match_a_o[0] : (tick_i && cks_runs(cks_i[1]));
      match_a_o[1] = ev1 && eq_a1;
      match_b_o[1] = ev1 && eq_b1;
      inc_o        = {ev1, ev0};
    end
  end

  always_comb begin
    clr_o[0] = clr_pick(clr_sel_i[0], match_a_o[0], match_b_o[0], ext_clr_i[0]);
    clr_o[1] = mode16_o ? clr_o[0]
             : clr_pick(clr_sel_i[1], match_a_o[1], match_b_o[1], ext_clr_i[1]);
  end
endmodule

// File: rtl/tmr_evt.sv
module tmr_evt
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       match_a_i,
  input  logic       match_b_i,
  input  logic [3:0] out_sel_i,
  input  logic       flag_clr_i,
  output logic       flag_a_o,
  output logic       flag_b_o,
  output logic       pin_o
);
  pin_act_e act;

  always_comb begin
    if (match_b_i)      act = pin_act_e'(out_sel_i[3:2]);
    else if (match_a_i) act = pin_act_e'(out_sel_i[1:0]);
    else                act = PA_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_a_o <= 1'b0;
      flag_b_o <= 1'b0;
      pin_o    <= 1'b0;
    end else begin
      if (match_a_i)       flag_a_o <= 1'b1;
      else if (flag_clr_i) flag_a_o <= 1'b0;
      if (match_b_i)       flag_b_o <= 1'b1;
      else if (flag_clr_i) flag_b_o <= 1'b0;
      case (act)
        PA_LOW:  pin_o <= 1'b0;
        PA_HIGH: pin_o <= 1'b1;
        PA_TOG:  pin_o <= ~pin_o;
        default: pin_o <= pin_o;
      endcase
    end
  end

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_a_i |=> flag_a_o); // R4
  AST_FLAG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_b_i && !flag_clr_i) |=> $stable(flag_b_o)); // R4
  AST_PIN_B_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_b_i && out_sel_i[3:2] == 2'b10) |=> pin_o); // R5
  AST_PIN_B_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_b_i && out_sel_i[3:2] == 2'b01) |=> !pin_o); // R5
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0][2:0]   cks_i,
  input  logic [1:0][1:0]   clr_sel_i,
  input  logic [1:0]        ext_clr_i,
  input  logic [1:0][W-1:0] cmp_a_i,
  input  logic [1:0][W-1:0] cmp_b_i,
  input  logic [1:0][3:0]   out_sel_i,
  input  logic [1:0]        flag_clr_i,
  output logic [1:0][W-1:0] cnt_o,
  output logic [1:0]        flag_a_o,
  output logic [1:0]        flag_b_o,
  output logic [1:0]        tmo_o
);
  localparam int NCH = 2;

  logic             mode16;
  logic [NCH-1:0]   inc, clr, match_a, match_b;

  tmr_mode #(.W(W)) u_mode (
    .tick_i    (tick_i),
    .cks_i     (cks_i),
    .clr_sel_i (clr_sel_i),
    .ext_clr_i (ext_clr_i),
    .cnt_i     (cnt_o),
    .cmp_a_i   (cmp_a_i),
    .cmp_b_i   (cmp_b_i),
    .mode16_o  (mode16),
    .inc_o     (inc),
    .clr_o     (clr),
    .match_a_o (match_a),
    .match_b_o (match_b)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_cnt #(.W(W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[g]),
      .clr_i  (clr[g]),
      .cnt_o  (cnt_o[g])
    );
    tmr_evt u_evt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .match_a_i  (match_a[g]),
      .match_b_i  (match_b[g]),
      .out_sel_i  (out_sel_i[g]),
      .flag_clr_i (flag_clr_i[g]),
      .flag_a_o   (flag_a_o[g]),
      .flag_b_o   (flag_b_o[g]),
      .pin_o      (tmo_o[g])
    );
  end

  AST_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode16 && tick_i && (&cnt_o[1]) && !clr[0])
    |=> (cnt_o[1] == '0) && (cnt_o[0] == $past(cnt_o[0]) + W'(1))); // R6
  AST_LOW_TIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode16 && tick_i && !clr[0]) |=> cnt_o[1] == $past(cnt_o[1]) + W'(1)); // R8
  AST_CHAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode16 && cks_i[1] == CKS_CHAIN && !clr[1])
    |=> cnt_o[1] == $past(cnt_o[1]) + W'($past(match_a[0]))); // R10
endmodule

// File: tb/tmr_pair_bench.sv
`timescale 1ns/1ps
module tmr_pair_bench;
  localparam int W = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tick = 1'b0;
  logic [1:0][2:0]   cks = '0;
  logic [1:0][1:0]   clr_sel = '0;
  logic [1:0]        ext_clr = '0;
  logic [1:0][W-1:0] cmp_a = '0;
  logic [1:0][W-1:0] cmp_b = '0;
  logic [1:0][3:0]   out_sel = '0;
  logic [1:0]        flag_clr = '0;
  logic [1:0][W-1:0] cnt;
  logic [1:0]        flag_a, flag_b, tmo;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  tmr_pair #(.W(W)) u_tmr_pair (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .cks_i(cks),
    .clr_sel_i(clr_sel), .ext_clr_i(ext_clr), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b),
    .out_sel_i(out_sel), .flag_clr_i(flag_clr), .cnt_o(cnt),
    .flag_a_o(flag_a), .flag_b_o(flag_b), .tmo_o(tmo)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic restart();
    rst_ni = 1'b0;
    tick = 1'b0; ext_clr = '0; flag_clr = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_zero();
    cks = '0; clr_sel = '0; cmp_a = '0; cmp_b = '0; out_sel = '0;
  endtask

  task automatic tick1();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ns [5] = '{0, 1, 5, 17, 254};
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt0", cnt[0], 0); chk("R1 cnt1", cnt[1], 0);
    chk("R1 flags", {flag_a, flag_b}, 0); chk("R1 pins", tmo, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", {cnt[0], cnt[1], flag_a, flag_b, tmo}, 0);

    // R2 free running, gating by tick and by code
    cfg_zero(); cks[0] = 3'b001; restart();
    for (int k = 1; k <= 5; k++) tick1();
    chk("R2 five ticks", cnt[0], 5); chk("R2 stopped ch1", cnt[1], 0);
    repeat (3) @(negedge clk);
    chk("R2 no tick holds", cnt[0], 5);
    cfg_zero(); cks[0] = 3'b101; cks[1] = 3'b011; restart();
    for (int k = 1; k <= 4; k++) tick1();
    chk("R2 code 101 holds", cnt[0], 0); chk("R2 code 011 runs", cnt[1], 4);

    // R3/R4 clear on A, sweep of compare values
    foreach (ns[i]) begin
      cfg_zero(); cks[0] = 3'b010; clr_sel[0] = 2'b01; cmp_a[0] = W'(ns[i]); restart();
      for (int k = 1; k <= 2 * ns[i] + 3; k++) begin
        tick1();
        chk("R3 clear on A", cnt[0], k % (ns[i] + 1));
        chk("R4 flag A", flag_a[0], int'(k >= ns[i] + 1));
      end
    end

    // R3 clear on B
    cfg_zero(); cks[0] = 3'b001; clr_sel[0] = 2'b10; cmp_b[0] = 3; cmp_a[0] = 1; restart();
    for (int k = 1; k <= 9; k++) begin
      tick1();
      chk("R3 clear on B", cnt[0], k % 4);
    end
    chk("R4 flags A and B", {flag_a[0], flag_b[0]}, 3);

    // R3 external clear, with and without tick
    cfg_zero(); cks[0] = 3'b001; clr_sel[0] = 2'b11; restart();
    for (int k = 1; k <= 7; k++) tick1();
    chk("R3 before pin clear", cnt[0], 7);
    ext_clr[0] = 1'b1; @(negedge clk); ext_clr[0] = 1'b0;
    chk("R3 pin clear", cnt[0], 0);
    for (int k = 1; k <= 3; k++) tick1();
    ext_clr[0] = 1'b1; tick1(); ext_clr[0] = 1'b0;
    chk("R3 clear beats count", cnt[0], 0);

    // R4 flag clear and set-wins
    cfg_zero(); cks[0] = 3'b001; clr_sel[0] = 2'b01; cmp_a[0] = 1; restart();
    tick1(); tick1();
    chk("R4 flag set", flag_a[0], 1);
    flag_clr[0] = 1'b1; tick1(); flag_clr[0] = 1'b0;
    chk("R4 flag cleared", flag_a[0], 0);
    flag_clr[0] = 1'b1; tick1(); flag_clr[0] = 1'b0;
    chk("R4 set wins over clear", flag_a[0], 1);

    // R5 A high, B low
    cfg_zero(); cks[0] = 3'b001; clr_sel[0] = 2'b10; cmp_a[0] = 2; cmp_b[0] = 4;
    out_sel[0] = 4'b0110; restart();
    for (int k = 1; k <= 10; k++) begin
      tick1();
      chk("R5 A high B low", tmo[0], int'((k % 5) == 3 || (k % 5) == 4));
    end
    // R5 toggle on A
    cfg_zero(); cks[0] = 3'b001; clr_sel[0] = 2'b01; cmp_a[0] = 1; out_sel[0] = 4'b0011; restart();
    for (int k = 1; k <= 8; k++) begin
      tick1();
      chk("R5 toggle", tmo[0], (k / 2) % 2);
    end
    // R5 B priority
    cfg_zero(); cks[0] = 3'b001; clr_sel[0] = 2'b01; cmp_a[0] = 3; cmp_b[0] = 3;
    out_sel[0] = 4'b1001; restart();
    for (int k = 1; k <= 4; k++) tick1();
    chk("R5 B wins", tmo[0], 1);

    // R6 16-bit count with carry; ch1 code ignored
    cfg_zero(); cks[0] = 3'b100; cks[1] = 3'b001; restart();
    for (int k = 1; k <= 300; k++) begin
      tick1();
      chk("R6 16-bit count", int'({cnt[0], cnt[1]}), k);
    end

    // R7/R8 16-bit match clear, ch1 clear ignored
    cfg_zero(); cks[0] = 3'b100; clr_sel[0] = 2'b01; cmp_a[0] = 1; cmp_a[1] = 4;
    clr_sel[1] = 2'b11; restart();
    ext_clr[1] = 1'b1;
    for (int k = 1; k <= 270; k++) begin
      tick1();
      chk("R8 16-bit clear", int'({cnt[0], cnt[1]}), k % 261);
      chk("R7 lower flag", flag_a[1], int'(k >= 5));
      chk("R7 full flag", flag_a[0], int'(k >= 261));
    end
    ext_clr[1] = 1'b0;
    // R8 external clear of whole count
    cfg_zero(); cks[0] = 3'b100; clr_sel[0] = 2'b11; restart();
    for (int k = 1; k <= 300; k++) tick1();
    ext_clr[0] = 1'b1; @(negedge clk); ext_clr[0] = 1'b0;
    chk("R8 pin clear both bytes", int'({cnt[0], cnt[1]}), 0);

    // R9 pins in 16-bit mode, ch1 match clear ignored
    cfg_zero(); cks[0] = 3'b100; cmp_a[0] = 1; cmp_a[1] = 3; clr_sel[1] = 2'b01;
    out_sel[0] = 4'b0010; out_sel[1] = 4'b0010; restart();
    for (int k = 1; k <= 262; k++) begin
      tick1();
      chk("R8 lower not cleared", int'({cnt[0], cnt[1]}), k);
      chk("R9 pin1 lower match", tmo[1], int'(k >= 4));
      chk("R9 pin0 full match", tmo[0], int'(k >= 260));
    end

    // R10 compare-match count mode
    cfg_zero(); cks[0] = 3'b001; clr_sel[0] = 2'b01; cmp_a[0] = 2;
    cks[1] = 3'b100; clr_sel[1] = 2'b01; cmp_a[1] = 2; out_sel[1] = 4'b0011; restart();
    for (int k = 1; k <= 30; k++) begin
      tick1();
      chk("R10 ch0 count", cnt[0], k % 3);
      chk("R10 ch1 count", cnt[1], (k / 3) % 3);
      chk("R10 ch1 flag", flag_a[1], int'(k >= 9));
      chk("R10 ch1 pin", tmo[1], (k / 9) % 2);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule